// File: doc/BRIEF.md
# Clocked Serial I/O Unit

This block is an 8-bit synchronous serial shifter with a small register interface. Writing a byte to the data register starts one exchange. Eight bits leave on `sout` and eight bits arrive on `sin`. Each bit is timed either by an internally generated shift clock or by an external clock pin. When the exchange ends, the data register holds the received byte, `busy` drops, and `done` pulses for one cycle.

The internal shift clock comes from two stages. A prescaler selects the base clock divided by 1, 8 or 32. A reload divider then divides that count source by n+1, and each terminal count toggles the shift clock. Control bits set the bit order, the output enable and the pin role. When the unit is not driving its pins, the level on the serial output is programmable. The control register accepts writes only while the protect input is high.

Register addresses on `reg_addr`: 0 is the data register, 1 is the control register, 2 is the divider, and 3 reads as zero. Reads are combinational.

Top module: `csio_unit`

## Requirements
- R1: After reset, the control register reads 0x40, `busy` and `done` are 0, and `sclk_out` is 1.
- R2: A control write takes effect only in a cycle where `prot_en` is 1. Control bit 4 always reads 0.
- R3: A data write while idle starts an exchange. `busy` stays high until the eighth rising shift edge. `done` is high for exactly the one cycle after that edge, and the data register then reads the received byte.
- R4: With the internal clock, each shift-clock half period lasts P*(n+1) clock cycles. P is 1, 8 or 32 for control bits [1:0] = 00, 01, 10, and n is the divider value. `sclk_out` idles high, so the first transition of an exchange is falling. `sclk_oe` is 1 when control bits 3 and 6 are both 1.
- R5: The serial output moves to the next bit only on a falling shift edge. `sin` is sampled on each rising shift edge.
- R6: Control bit 5 = 0 sends and assembles LSB first. Bit 5 = 1 sends and assembles MSB first.
- R7: Control bit 2 = 1 drives `sout_oe` low. Bit 2 = 0 drives it high.
- R8: With control bit 3 = 0 (port mode), `sout` equals control bit 7 and `sclk_oe` is 0.
- R9: With control bit 6 = 0, the shift edges come from `sclk_in`. The pin passes through a two-stage synchronizer and an edge detector.
- R10: While `busy` is 1, writes to the divider and to the data register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| prot_en | input | 1 | Allows control register writes |
| sin | input | 1 | Serial data in |
| sclk_in | input | 1 | External shift clock |
| sout | output | 1 | Serial data out |
| sout_oe | output | 1 | Output enable for `sout` |
| sclk_out | output | 1 | Internal shift clock |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse when an exchange completes |

## Verification
The bench builds the unit with its default prescale ratios of 8 and 32. Divider values of 0 to 5 keep every half period between 1 and 64 cycles, so all three prescale codes, both bit orders and the n = 0 case of a one-cycle half period each run a full exchange. A reference model then compares every cycle. Writes that arrive during an exchange are placed at known cycles of the n = 5 run. The external-clock run uses a slow pin toggle, which exposes the synchronizer latency.

// File: rtl/csio_pkg.sv
// Package: shared register addresses and control layout for the serial unit.
// Assumes an 8-bit register interface with a 2-bit address.
package csio_pkg;
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_DIV  = 2'd2;

    localparam logic [7:0] CTRL_RESET = 8'h40;
    localparam logic [7:0] CTRL_WMASK = 8'hEF;

    typedef struct packed {
        logic       idle_lvl;   // bit 7
        logic       int_clk;    // bit 6
        logic       msb_first;  // bit 5
        logic       rsv;        // bit 4
        logic       pin_en;     // bit 3
        logic       out_off;    // bit 2
        logic [1:0] psc_sel;    // bits 1:0
    } ctrl_t;
endpackage

// File: rtl/csio_clkgen.sv
// Module: internal shift-clock generator. A prescaler picks a count source
// (1, PSC_MID or PSC_HI base cycles). A reload divider counts n+1 source ticks
// and then toggles the shift clock. Assumes 'start' restarts both counters
// and that 'run' stays high only while an exchange is active.
module csio_clkgen #(
    parameter int PSC_MID = 8,
    parameter int PSC_HI  = 32,
    parameter int DIV_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [1:0]       psc_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             fall_ev,
    output logic             rise_ev,
    output logic             sclk
);
    localparam int PW = $clog2(PSC_HI);

    logic [PW-1:0]    psc_cnt;
    logic [PW-1:0]    psc_lim;
    logic [DIV_W-1:0] div_cnt;
    logic             src_tick;
    logic             term;

    // Terminal value of the prescaler for the selected ratio.
    always_comb begin
        case (psc_sel)
            2'b00:   psc_lim = '0;
            2'b01:   psc_lim = PW'(PSC_MID - 1);
            default: psc_lim = PW'(PSC_HI - 1);
        endcase
    end

    assign src_tick = run && (psc_cnt == psc_lim);
    assign term     = src_tick && (div_cnt == div_n);

    // Prescaler counter: wraps on each count-source tick.
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            psc_cnt <= '0;
        else if (run)
            psc_cnt <= src_tick ? '0 : psc_cnt + 1'b1;
    end

    // Reload divider: counts source ticks from 0 up to n.
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            div_cnt <= '0;
        else if (src_tick)
            div_cnt <= term ? '0 : div_cnt + 1'b1;
    end

    // Shift clock: idles high and toggles at each divider terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            sclk <= 1'b1;
        else if (term)
            sclk <= ~sclk;
    end

    assign fall_ev = term && sclk;
    assign rise_ev = term && !sclk;
endmodule

// File: rtl/csio_extedge.sv
// Module: external shift-clock edge detector. The pin passes through two
// synchronizing flops, and a third flop keeps the previous level. Assumes the
// pin stays high while idle and is slow compared with clk.
module csio_extedge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic en,
    output logic fall_ev,
    output logic rise_ev
);
    logic [2:0] sync_q;

    // Synchronizer and history chain for the external clock pin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= 3'b111;
        else
            sync_q <= {sync_q[1:0], sclk_in};
    end

    assign fall_ev = en && sync_q[2] && !sync_q[1];
    assign rise_ev = en && !sync_q[2] && sync_q[1];
endmodule

// File: rtl/csio_shifter.sv
// Module: combined transmit/receive shift register. A falling event presents
// the next outgoing bit. A rising event shifts in 'sin'. The W-th rising
// event ends the exchange. Assumes fall and rise never arrive together.
module csio_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         fall,
    input  logic         rise,
    input  logic         msb_first,
    input  logic         sin,
    output logic         sout_bit,
    output logic [W-1:0] data,
    output logic         busy,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] bit_cnt;
    logic          last_rise;

    assign last_rise = busy && rise && (bit_cnt == CW'(W - 1));

    // Shift register: loaded by a data write, then shifted on rising events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (load)
            data <= load_data;
        else if (busy && rise)
            data <= msb_first ? {data[W-2:0], sin} : {sin, data[W-1:1]};
    end

    // Output bit: takes the outgoing end of the register on falling events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sout_bit <= 1'b0;
        else if (busy && fall)
            sout_bit <= msb_first ? data[W-1] : data[0];
    end

    // Bit counter: counts the rising events of the current exchange.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            bit_cnt <= '0;
        else if (busy && rise)
            bit_cnt <= bit_cnt + 1'b1;
    end

    // Busy flag: set by a load, cleared on the last rising event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (load)
            busy <= 1'b1;
        else if (last_rise)
            busy <= 1'b0;
    end

    // Completion pulse: high for one cycle after the last rising event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= last_rise;
    end
endmodule

// File: rtl/csio_unit.sv
// Module: clocked serial I/O unit top. It holds the control and divider
// registers, decodes register writes and reads, selects the internal or
// external shift clock, and drives the pin-side outputs.
// Assumes one register access per cycle and that sclk_in idles high.
module csio_unit #(
    parameter int PSC_MID = 8,
    parameter int PSC_HI  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       prot_en,
    input  logic       sin,
    input  logic       sclk_in,
    output logic       sout,
    output logic       sout_oe,
    output logic       sclk_out,
    output logic       sclk_oe,
    output logic       busy,
    output logic       done
);
    import csio_pkg::*;

    localparam int W = 8;

    ctrl_t        ctrl_q;
    logic [W-1:0] div_q;
    logic [W-1:0] shreg;
    logic         load;
    logic         int_fall, int_rise, ext_fall, ext_rise;
    logic         sh_fall, sh_rise;
    logic         sout_bit;
    logic         sclk_int;

    assign load = reg_we && (reg_addr == ADDR_DATA) && !busy;

    // Control register: protect-gated, reserved bit forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= ctrl_t'(CTRL_RESET);
        else if (reg_we && (reg_addr == ADDR_CTRL) && prot_en)
            ctrl_q <= ctrl_t'(reg_wdata & CTRL_WMASK);
    end

    // Divider register: writable only between exchanges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (reg_we && (reg_addr == ADDR_DIV) && !busy)
            div_q <= reg_wdata;
    end

    csio_clkgen #(
        .PSC_MID (PSC_MID),
        .PSC_HI  (PSC_HI),
        .DIV_W   (W)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (load),
        .run     (busy && ctrl_q.int_clk),
        .psc_sel (ctrl_q.psc_sel),
        .div_n   (div_q),
        .fall_ev (int_fall),
        .rise_ev (int_rise),
        .sclk    (sclk_int)
    );

    csio_extedge u_extedge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_in),
        .en      (busy && !ctrl_q.int_clk),
        .fall_ev (ext_fall),
        .rise_ev (ext_rise)
    );

    assign sh_fall = ctrl_q.int_clk ? int_fall : ext_fall;
    assign sh_rise = ctrl_q.int_clk ? int_rise : ext_rise;

    csio_shifter #(.W(W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (reg_wdata),
        .fall      (sh_fall),
        .rise      (sh_rise),
        .msb_first (ctrl_q.msb_first),
        .sin       (sin),
        .sout_bit  (sout_bit),
        .data      (shreg),
        .busy      (busy),
        .done      (done)
    );

    // Read mux for the register interface.
    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = shreg;
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_DIV:  reg_rdata = div_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign sout     = ctrl_q.pin_en ? sout_bit : ctrl_q.idle_lvl;
    assign sout_oe  = !ctrl_q.out_off;
    assign sclk_out = sclk_int;
    assign sclk_oe  = ctrl_q.pin_en && ctrl_q.int_clk;
endmodule

// File: rtl/csio_unit_chk.sv
// Module: property checker for csio_unit, attached by bind.
module csio_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prot_en,
    input logic       busy,
    input logic       done,
    input logic       sclk_out,
    input logic       sout_bit,
    input logic       sh_fall,
    input logic [7:0] ctrl_q,
    input logic [7:0] div_q
);
    // R3: the completion pulse follows a busy cycle and finds the unit idle.
    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R4: the shift clock rests high whenever no exchange runs.
    a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_out);

    // R5: the outgoing bit moves only after a falling shift event.
    a_r5_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sout_bit) |-> $past(sh_fall));

    // R10: the divider holds its value across busy cycles.
    a_r10_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(div_q));

    // R2: the control register cannot change after a cycle without protect enable.
    a_r2_protect_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(prot_en) |-> $stable(ctrl_q));
endmodule

bind csio_unit csio_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prot_en  (prot_en),
    .busy     (busy),
    .done     (done),
    .sclk_out (sclk_out),
    .sout_bit (sout_bit),
    .sh_fall  (sh_fall),
    .ctrl_q   (ctrl_q),
    .div_q    (div_q)
);

// File: tb/csio_unit_bench.sv
module csio_unit_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       prot_en = 1'b0;
    logic       sin = 1'b0;
    logic       sclk_in = 1'b1;
    logic       sout, sout_oe, sclk_out, sclk_oe, busy, done;

    int n_chk = 0;
    int n_fail = 0;
    int done_seen = 0;
    logic prev_sout = 1'b0;

    csio_unit u_csio_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prot_en(prot_en),
        .sin(sin), .sclk_in(sclk_in), .sout(sout), .sout_oe(sout_oe),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .busy(busy), .done(done)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) if (done) done_seen++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] x);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = x[7-i];
        return r;
    endfunction

    // Internal-clock exchange compared against the model on every clock.
    task automatic run_int(input logic [1:0] psc, input int n, input bit msb,
                           input logic [7:0] tx, input logic [7:0] pat, input bit meddle);
        int p, h, c, m, idx;
        logic e_sout;
        logic [7:0] v;
        p = (psc == 2'b00) ? 1 : (psc == 2'b01) ? 8 : 32;
        h = p * (n + 1);
        wr(2'd1, 8'h48 | (msb ? 8'h20 : 8'h00) | {6'b0, psc});
        wr(2'd2, 8'(n));
        done_seen = 0;
        wr(2'd0, tx);
        c = 0;
        sin = pat[0];
        e_sout = prev_sout;
        chk("R4 sclk_oe on", int'(sclk_oe), 1);
        while (c < 16 * h + 2) begin
            @(posedge clk); #1;
            c++;
            m = c / h;
            if (m > 16) m = 16;
            if (m >= 1) begin
                idx = (m - 1) / 2;
                if (idx > 7) idx = 7;
                e_sout = msb ? tx[7-idx] : tx[idx];
            end
            chk("R4 sclk_out", int'(sclk_out), int'(m % 2 == 0));
            chk("R3 busy", int'(busy), int'(c < 16 * h));
            chk("R3 done", int'(done), int'(c == 16 * h));
            chk("R5 sout", int'(sout), int'(e_sout));
            sin = pat[(c / (2 * h)) % 8];
            if (meddle && c == 3) begin
                reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h33;
            end else if (meddle && c == 4) begin
                reg_addr = 2'd0; reg_wdata = 8'hAA;
            end else if (meddle && c == 5) begin
                reg_we = 1'b0;
            end
        end
        prev_sout = e_sout;
        chk("R3 single done pulse", done_seen, 1);
        rd(2'd0, v);
        chk(msb ? "R6 msb-first rx" : "R6 lsb-first rx", int'(v), int'(msb ? rev8(pat) : pat));
        rd(2'd2, v);
        chk("R10 divider kept", int'(v), n);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        rd(2'd1, v);
        chk("R1 ctrl reset", int'(v), 8'h40);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 sclk_out", int'(sclk_out), 1);

        // R2: protect gate and reserved bit
        wr(2'd1, 8'hFF);
        rd(2'd1, v);
        chk("R2 blocked write", int'(v), 8'h40);
        prot_en = 1'b1;
        wr(2'd1, 8'hFF);
        rd(2'd1, v);
        chk("R2 bit4 reads 0", int'(v), 8'hEF);

        // R7: output disable
        chk("R7 sout_oe off", int'(sout_oe), 0);
        wr(2'd1, 8'h48);
        chk("R7 sout_oe on", int'(sout_oe), 1);

        // R8: port mode idle level
        wr(2'd1, 8'hC0);
        chk("R8 sout high", int'(sout), 1);
        chk("R8 sclk_oe off", int'(sclk_oe), 0);
        wr(2'd1, 8'h40);
        chk("R8 sout low", int'(sout), 0);

        // R3 R4 R5 R6 R10: internal-clock exchanges
        run_int(2'b00, 0, 1'b0, 8'hA5, 8'h3C, 1'b0);
        run_int(2'b00, 5, 1'b1, 8'h96, 8'hC1, 1'b1);
        run_int(2'b01, 2, 1'b0, 8'h0F, 8'h81, 1'b0);
        run_int(2'b10, 1, 1'b1, 8'hE2, 8'h5A, 1'b0);

        // R9: external clock exchange, LSB first
        wr(2'd1, 8'h08);
        chk("R9 sclk_oe off", int'(sclk_oe), 0);
        done_seen = 0;
        wr(2'd0, 8'h6B);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0;
            tick(3);
            sin = v[0] ^ 1'b0;
            sin = 8'hD4 >> i;
            tick(3);
            chk("R9 ext sout", int'(sout), int'((8'h6B >> i) & 1));
            sclk_in = 1'b1;
            tick(6);
        end
        tick(4);
        chk("R9 busy cleared", int'(busy), 0);
        chk("R9 done pulse", done_seen, 1);
        rd(2'd0, v);
        chk("R9 ext rx", int'(v), 8'hD4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule